// File: doc/BRIEF.md
# Programmable Shape Envelope Generator

This block produces a 4-bit amplitude envelope that the tone and noise channels of a sound unit use as their volume when their envelope select bit is set. The level walks up or down one step at a time. The step rate comes from a 16-bit delay value and a fixed prescaler: the prescaler divides the system clock by 32 into base ticks, and the level moves once every (delay + 1) base ticks. A delay of 0 gives the fastest ramp, and 0xFFFF gives a ramp so slow that the envelope looks almost static.

A 4-bit shape code picks the ramp pattern. Bit 2 selects a rising start; otherwise the ramp falls. Bit 3 clear gives a single ramp that then drops to zero. With bit 3 set, bit 0 asks for a single ramp, and bit 1 then selects which level is held afterwards. When bit 0 is clear, bit 1 picks a triangle instead of a sawtooth. Each write of the shape restarts the envelope from the first level of the new ramp and clears the prescaler. The block does no volume mixing and no analog shaping.

Top module: `env_shaper`

## Requirements
- R1: After reset the level is 0 and stays at 0 until a shape is written.
- R2: A write to the shape (shape_we high, code in wdata[3:0]) sets the level in the next cycle to 15 when wdata[2] is 0 and to 0 when wdata[2] is 1, and restarts the step timing.
- R3: With delay D (wdata bytes: dly_lo_we loads bits 7:0, dly_hi_we loads bits 15:8), the level changes every 32*(D+1) clock cycles, counted from the shape write. D = 0 is the fastest rate.
- R4: Shape codes 0 to 7 run one ramp: falling 15 to 0 when bit 2 is 0, rising 0 to 15 when bit 2 is 1. At the step after the last ramp level, the level becomes 0 and stays there.
- R5: Codes 8 (falling) and 0xC (rising) repeat as a sawtooth. After 0, a falling ramp jumps to 15. After 15, a rising ramp jumps to 0. The period is 16 steps.
- R6: Codes 0xA (first falling) and 0xE (first rising) repeat as a triangle that reverses direction at 0 and 15. The full cycle is 30 steps, about twice the sawtooth period.
- R7: Codes 9 (falling) and 0xF (rising) run one ramp and then hold 0.
- R8: Codes 0xB (falling) and 0xD (rising) run one ramp and then hold 15.
- R9: A delay write does not restart the envelope and leaves the current level unchanged.
- R10: The level changes only on a step or a shape write. Once a single ramp has ended, the level stays fixed until the next shape write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dly_lo_we | input | 1 | Load wdata into delay bits 7:0 |
| dly_hi_we | input | 1 | Load wdata into delay bits 15:8 |
| shape_we | input | 1 | Load wdata[3:0] as the shape code and restart |
| wdata | input | 8 | Write data |
| level | output | 4 | Current envelope level |

## Verification
The assertions assume that at most one of the three write strobes is high in any cycle, and that the strobes and wdata are stable and defined around each rising edge after reset. The bench drives each write in a task that raises one strobe for exactly one cycle, changes inputs only on the falling edge, and leaves a full step period or more between a shape write and any later delay write. Because of this, every restart and every delay update falls in a cycle with no step.

// File: rtl/env_shaper.sv
module env_shaper #(
  parameter int DIV = 32,
  parameter int LW  = 4,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dly_lo_we,
  input  logic          dly_hi_we,
  input  logic          shape_we,
  input  logic [7:0]    wdata,
  output logic [LW-1:0] level
);
  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);
  localparam logic [LW-1:0] TOP = {LW{1'b1}};

  logic [PW-1:0] pre;
  logic [DW-1:0] dly, stc;
  logic [3:0]    shp;
  logic [LW-1:0] lvl;
  logic          up, done;

  wire tick    = (pre == PRE_LAST);
  wire step    = tick && (stc >= dly);
  wire once    = ~shp[3] | shp[0];
  wire tri_rep = shp[3] & shp[1] & ~shp[0];
  wire hold_hi = shp[3] & (shp[1] ^ shp[2]);
  wire at_end  = up ? (lvl == TOP) : (lvl == '0);

  assign level = lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dly <= '0;
    else if (dly_lo_we) dly[7:0] <= wdata;
    else if (dly_hi_we) dly[DW-1:8] <= wdata[DW-9:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre <= '0; stc <= '0; shp <= '0;
      lvl <= '0; up <= 1'b0; done <= 1'b1;
    end else if (shape_we) begin
      pre  <= '0;
      stc  <= '0;
      shp  <= wdata[3:0];
      up   <= wdata[2];
      lvl  <= wdata[2] ? '0 : TOP;
      done <= 1'b0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) stc <= step ? '0 : stc + 1'b1;
      if (step && !done) begin
        if (at_end) begin
          if (once) begin
            lvl  <= hold_hi ? TOP : '0;
            done <= 1'b1;
          end else if (tri_rep) begin
            up  <= ~up;
            lvl <= up ? lvl - 1'b1 : lvl + 1'b1;
          end else
            lvl <= up ? '0 : TOP;
        end else
          lvl <= up ? lvl + 1'b1 : lvl - 1'b1;
      end
    end

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shape_we |=> level == ($past(wdata[2]) ? '0 : TOP));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!shape_we && !tick) |=> $stable(level));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !shape_we) |=> $stable(level) && done);

  assert_delay_norestart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((dly_lo_we || dly_hi_we) && !shape_we && !tick) |=> $stable(level));

  assert_repeat_never_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shp[3] && !shp[0] && !done && !shape_we) |=> !done);

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!shape_we && !done && !(at_end)) |=> (level == $past(level)) ||
      (level == $past(level) + 1'b1) || (level == $past(level) - 1'b1));
endmodule

// File: tb/env_shaper_tb.sv
module env_shaper_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dly_lo_we = 1'b0, dly_hi_we = 1'b0, shape_we = 1'b0;
  logic [7:0] wdata = '0;
  logic [3:0] level;
  int checks = 0, failures = 0;
  bit finished = 0;

  typedef struct { logic [3:0] lvl; int wt; string tag; } item_t;
  item_t q[$];
  bit busy = 0;

  always #4 clk = ~clk;

  env_shaper u_dut (.clk(clk), .rst_n(rst_n), .dly_lo_we(dly_lo_we),
    .dly_hi_we(dly_hi_we), .shape_we(shape_we), .wdata(wdata), .level(level));

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s level=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input int kind, input logic [7:0] d);
    @(negedge clk);
    wdata = d;
    dly_lo_we = (kind == 0); dly_hi_we = (kind == 1); shape_we = (kind == 2);
    @(posedge clk); #1;
    dly_lo_we = 0; dly_hi_we = 0; shape_we = 0;
  endtask

  task automatic drain();
    wait (q.size() == 0 && !busy);
  endtask

  // expected envelope built from the shape rules, pushed for the monitor
  task automatic run_shape(input logic [3:0] s, input int d, input int n, input string tag);
    int per = 32 * (d + 1);
    logic up = s[2];
    logic once = !s[3] || s[0];
    logic tri_m = s[3] && s[1] && !s[0];
    logic hi = s[3] && (s[1] != s[2]);
    logic dn = 0;
    int lv;
    wr(0, d[7:0]);
    wr(1, d[15:8]);
    wr(2, {4'h0, s});
    lv = up ? 0 : 15;
    q.push_back('{lvl: 4'(lv), wt: 0, tag: tag});
    for (int i = 0; i < n; i++) begin
      if (!dn) begin
        if ((up && lv == 15) || (!up && lv == 0)) begin
          if (once) begin lv = hi ? 15 : 0; dn = 1; end
          else if (tri_m) begin up = !up; lv = up ? lv + 1 : lv - 1; end
          else lv = up ? 0 : 15;
        end else lv = up ? lv + 1 : lv - 1;
      end
      q.push_back('{lvl: 4'(lv), wt: per, tag: tag});
    end
    drain();
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      wait (q.size() > 0);
      busy = 1;
      it = q.pop_front();
      repeat (it.wt) @(posedge clk);
      @(negedge clk);
      chk(level, it.lvl, it.tag);
      busy = 0;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(level, 4'd0, "R1 reset level");
    rst_n = 1;
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(level, 4'd0, "R1 idle after reset");

    run_shape(4'h0, 0, 19, "R4 shape0 fall once");
    run_shape(4'h3, 0, 18, "R4 shape3 fall once");
    run_shape(4'h5, 0, 19, "R4 shape5 rise once then zero");
    run_shape(4'h8, 0, 20, "R5 shape8 saw fall");
    run_shape(4'hC, 0, 20, "R5 shapeC saw rise");
    run_shape(4'hA, 0, 34, "R6 shapeA triangle");
    run_shape(4'hE, 0, 34, "R6 shapeE triangle");
    run_shape(4'h9, 0, 18, "R7 shape9 once low");
    run_shape(4'hF, 0, 18, "R7 shapeF once low");
    run_shape(4'hB, 0, 18, "R8 shapeB once high");
    run_shape(4'hD, 0, 18, "R8 shapeD once high");
    run_shape(4'h8, 2, 4, "R3 delay 2 period 96");
    run_shape(4'hC, 259, 1, "R3 delay 259 both bytes");

    // restart mid-ramp: shape write after a few steps returns to start
    run_shape(4'h8, 0, 3, "R2 pre-restart");
    run_shape(4'h4, 0, 2, "R2 restart to rising start");

    // delay write does not restart: level kept, next step after new period
    wr(0, 8'd0);
    q.push_back('{lvl: 4'd2, wt: 0, tag: "R9 level kept on delay write"});
    drain();
    q.push_back('{lvl: 4'd2, wt: 16, tag: "R10 stable between steps"});
    drain();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule